// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog peripheral that sits on a plain 32-bit register bus. It holds a programmable timeout, counted in input clock ticks, and a down-counter. When the counter runs out, the block raises a reset-request pulse. Software converts milliseconds into ticks itself, by dividing the clock rate by one thousand and multiplying by the timeout.

Single writes cannot arm or disarm the watchdog. Software arms it, or refreshes a running count, by writing a two-word arming key to the control register. It disarms it with a different two-word key. The second word of a key only counts when it is the next bus write after the first word. Because of this, one stray write cannot start the watchdog or kill it.

Bus writes are single-cycle strobes. Reads are combinational from the address. The bus carries no data stream, so it has no valid/ready handshake and no back-pressure: every write is accepted on the clock edge where it appears.

Top module: `wdk_top`

## Requirements
- R1: After reset, the limit register (offset 0x0) reads 0xFFFFFFFE, the control register (offset 0x4) reads 0, and `wdt_rst_req` is low.
- R2: Offset 0x0 reads back the programmed limit exactly as written. Offset 0x4 reads the running flag in bit 0, with all other bits zero. Any other offset reads 0, and a write to any other offset changes no register.
- R3: Writing 0x0000FF00 and then 0x000000FF to offset 0x4 arms the watchdog. The counter loads on the clock edge that captures the second word, and bit 0 of offset 0x4 reads 1 from then on.
- R4: Writing 0x0000EE00 and then 0x000000EE to offset 0x4 clears the running flag. No reset request follows.
- R5: The second key word counts only if it arrives on the next bus write after the first key word. Any write in between cancels the partial key, including a write to another offset, a wrong word, or the other key's first word. A second key word written alone has no effect.
- R6: `wdt_rst_req` goes high exactly N clock cycles after the load edge. N is the programmed limit clamped to the range 2 to 0xFFFFFFFE, so 0 and 1 act as 2 and 0xFFFFFFFF acts as 0xFFFFFFFE.
- R7: The reset request lasts exactly one cycle. On that cycle the running flag is already 0, and no further request comes until the watchdog is armed again.
- R8: Arming while running (a refresh) reloads the counter from the limit register, so a full N cycles elapse from the refresh load edge.
- R9: Writing the limit while running leaves the current countdown unchanged. The new value is used at the next arm or refresh.
- R10: If an arm completes on the same edge where the count would expire, the reload wins and no reset request is issued for that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_rst_req | output | 1 | One-cycle reset-request pulse on expiry |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` hold known values at every clock edge after reset. They also assume that a write is a single-cycle strobe, so a held strobe counts as a new write on each edge. The bench meets these assumptions by changing bus inputs only on the falling edge and dropping `bus_wr` after each captured write. Timeouts are kept small so that expiry windows are measured cycle by cycle. The largest limit is checked only for the absence of an early expiry.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int WDK_DW = 32;
  localparam int WDK_AW = 3;

  localparam logic [WDK_DW-1:0] KEY_ARM_HI  = 32'h0000_FF00;
  localparam logic [WDK_DW-1:0] KEY_ARM_LO  = 32'h0000_00FF;
  localparam logic [WDK_DW-1:0] KEY_HALT_HI = 32'h0000_EE00;
  localparam logic [WDK_DW-1:0] KEY_HALT_LO = 32'h0000_00EE;

  localparam int OFS_LIMIT = 0;
  localparam int OFS_CTRL  = 4;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_RUN  = 2'd1,
    ARM_HALT = 2'd2
  } arm_state_e;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int DW = WDK_DW,
  parameter int AW = WDK_AW,
  parameter logic [DW-1:0] LIMIT_RST = {{(DW-1){1'b1}}, 1'b0}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          running,
  output logic [DW-1:0] limit_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] A_LIMIT = AW'(OFS_LIMIT);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);

  logic [DW-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      limit_q <= LIMIT_RST;
    else if (wr_en && addr == A_LIMIT)
      limit_q <= wdata;
  end

  always_comb begin
    rdata_o = '0;
    if (addr == A_LIMIT)
      rdata_o = limit_q;
    else if (addr == A_CTRL)
      rdata_o = {{(DW-1){1'b0}}, running};
  end

  assign limit_o = limit_q;
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int DW = WDK_DW,
  parameter int AW = WDK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          arm_o,
  output logic          halt_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  arm_state_e state_q, state_d;
  logic       ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);

  always_comb begin
    arm_o   = 1'b0;
    halt_o  = 1'b0;
    state_d = state_q;
    if (wr_en) begin
      if (ctrl_wr && state_q == ARM_RUN && wdata == KEY_ARM_LO)
        arm_o = 1'b1;
      if (ctrl_wr && state_q == ARM_HALT && wdata == KEY_HALT_LO)
        halt_o = 1'b1;
      if (ctrl_wr && wdata == KEY_ARM_HI)
        state_d = ARM_RUN;
      else if (ctrl_wr && wdata == KEY_HALT_HI)
        state_d = ARM_HALT;
      else
        state_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ARM_IDLE;
    else
      state_q <= state_d;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
#(
  parameter int DW = WDK_DW,
  parameter int MIN_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          halt,
  input  logic [DW-1:0] limit,
  output logic          running_o,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  localparam logic [DW-1:0] LO_BOUND = DW'(MIN_TICKS);
  localparam logic [DW-1:0] HI_BOUND = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] ONE      = DW'(1);

  logic [DW-1:0] count_q, load_val;
  logic          run_q, exp_q;

  always_comb begin
    if (limit < LO_BOUND)
      load_val = LO_BOUND;
    else if (limit > HI_BOUND)
      load_val = HI_BOUND;
    else
      load_val = limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (arm) begin
        count_q <= load_val;
        run_q   <= 1'b1;
      end else if (halt) begin
        count_q <= '0;
        run_q   <= 1'b0;
      end else if (run_q) begin
        if (count_q == ONE) begin
          count_q <= '0;
          run_q   <= 1'b0;
          exp_q   <= 1'b1;
        end else begin
          count_q <= count_q - ONE;
        end
      end
    end
  end

  assign running_o = run_q;
  assign count_o   = count_q;
  assign expire_o  = exp_q;
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int DW = WDK_DW,
  parameter int AW = WDK_AW,
  parameter int MIN_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_rst_req
);
  logic          key_arm, key_halt, run_flag;
  logic [DW-1:0] limit_val, tick_cnt;

  wdk_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .running(run_flag), .limit_o(limit_val),
    .rdata_o(bus_rdata)
  );

  wdk_keyseq #(.DW(DW), .AW(AW)) keys_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .arm_o(key_arm), .halt_o(key_halt)
  );

  wdk_counter #(.DW(DW), .MIN_TICKS(MIN_TICKS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .arm(key_arm), .halt(key_halt),
    .limit(limit_val), .running_o(run_flag), .count_o(tick_cnt),
    .expire_o(wdt_rst_req)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int DW = 32,
  parameter int MIN_TICKS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          halt,
  input logic          running,
  input logic [DW-1:0] count,
  input logic          expire
);
  localparam logic [DW-1:0] LO_B = DW'(MIN_TICKS);
  localparam logic [DW-1:0] HI_B = {{(DW-1){1'b1}}, 1'b0};

  AST_KEYS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm, halt})); // R5
  AST_LOAD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (running && count >= LO_B && count <= HI_B)); // R6
  AST_TICK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !arm && !halt && count > DW'(1)) |=> (count == $past(count) - DW'(1))); // R6
  AST_EXPIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !arm && !halt && count == DW'(1)) |=> expire); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R7
  AST_STOPPED_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !running); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!running && !expire)); // R4
  AST_ARM_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !expire); // R10
endmodule

bind wdk_top wdk_checker #(.DW(DW), .MIN_TICKS(MIN_TICKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(key_arm), .halt(key_halt),
  .running(run_flag), .count(tick_cnt), .expire(wdt_rst_req)
);

// File: tb/wdk_top_tb_top.sv
`timescale 1ns/1ps
module wdk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdk_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  localparam int NV = 6;
  localparam logic [31:0] VEC_PROG [NV] = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd10, 32'd37};
  localparam int          VEC_WAIT [NV] = '{2, 2, 2, 3, 10, 37};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic arm_seq();
    wr(3'd4, 32'h0000_FF00);
    wr(3'd4, 32'h0000_00FF);
  endtask

  task automatic halt_seq();
    wr(3'd4, 32'h0000_EE00);
    wr(3'd4, 32'h0000_00EE);
  endtask

  // Count cycles from the current falling edge until the first pulse; 0 if none.
  task automatic wait_pulse(input int limit, output int hit);
    hit = 0;
    for (int k = 1; k <= limit && hit == 0; k++) begin
      @(negedge clk);
      if (wdt_rst_req) hit = k;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk("R1 limit", r, 32'hFFFF_FFFE);
    rd(3'd4, r); chk("R1 ctrl", r, 32'h0);
    chk("R1 req", {31'b0, wdt_rst_req}, 32'h0);

    // R2 map: unmapped offsets read 0, writes there ignored
    rd(3'd2, r); chk("R2 unmapped read", r, 32'h0);
    wr(3'd6, 32'h0000_0005);
    rd(3'd0, r); chk("R2 unmapped write", r, 32'hFFFF_FFFE);

    // R6 vector table walk (R3 running flag, R7 pulse shape)
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC_PROG[i]);
      rd(3'd0, r); chk("R2 readback", r, VEC_PROG[i]);
      arm_seq();
      rd(3'd4, r); chk("R3 running", r, 32'h1);
      wait_pulse(VEC_WAIT[i] + 4, hit);
      chk("R6 expiry cycles", hit, VEC_WAIT[i]);
      rd(3'd4, r); chk("R7 stopped at pulse", r, 32'h0);
      @(negedge clk);
      chk("R7 single cycle", {31'b0, wdt_rst_req}, 32'h0);
      wait_pulse(VEC_WAIT[i] + 4, hit);
      chk("R7 no repeat", hit, 0);
    end

    // R4 stop
    wr(3'd0, 32'd30);
    arm_seq();
    repeat (5) @(negedge clk);
    halt_seq();
    rd(3'd4, r); chk("R4 stopped", r, 32'h0);
    wait_pulse(40, hit); chk("R4 no pulse", hit, 0);

    // R5 broken sequences while stopped
    wr(3'd4, 32'h0000_FF00); wr(3'd0, 32'd30); wr(3'd4, 32'h0000_00FF);
    rd(3'd4, r); chk("R5 limit write between", r, 32'h0);
    wr(3'd4, 32'h0000_FF00); wr(3'd4, 32'h0000_00EE);
    rd(3'd4, r); chk("R5 mixed keys", r, 32'h0);
    wr(3'd4, 32'h0000_00FF);
    rd(3'd4, r); chk("R5 lone second word", r, 32'h0);
    wr(3'd4, 32'h0000_FF00); wr(3'd4, 32'h0000_EE00); wr(3'd4, 32'h0000_00FF);
    rd(3'd4, r); chk("R5 other first word", r, 32'h0);
    wr(3'd4, 32'h0000_FF00); wr(3'd6, 32'h0); wr(3'd4, 32'h0000_00FF);
    rd(3'd4, r); chk("R5 unmapped write between", r, 32'h0);
    // R5 broken stop while running
    wr(3'd0, 32'd200);
    arm_seq();
    wr(3'd4, 32'h0000_EE00); wr(3'd4, 32'h0000_0001); wr(3'd4, 32'h0000_00EE);
    rd(3'd4, r); chk("R5 broken stop", r, 32'h1);
    halt_seq();

    // R8 refresh reloads full period
    wr(3'd0, 32'd12);
    arm_seq();
    wait_pulse(6, hit); chk("R8 no early pulse", hit, 0);
    arm_seq();
    wait_pulse(20, hit); chk("R8 refresh period", hit, 12);

    // R9 limit write while running
    wr(3'd0, 32'd15);
    arm_seq();
    wr(3'd0, 32'd4);
    wait_pulse(30, hit); chk("R9 unchanged countdown", hit, 14);
    rd(3'd0, r); chk("R9 new limit", r, 32'd4);
    arm_seq();
    wait_pulse(10, hit); chk("R9 used at next arm", hit, 4);

    // R6 upper clamp: all-ones limit does not expire early
    wr(3'd0, 32'hFFFF_FFFF);
    arm_seq();
    wait_pulse(50, hit); chk("R6 max no early pulse", hit, 0);
    rd(3'd4, r); chk("R6 max running", r, 32'h1);
    rd(3'd0, r); chk("R2 all-ones readback", r, 32'hFFFF_FFFF);
    halt_seq();

    // R10 arm on the expiry edge
    wr(3'd0, 32'd3);
    arm_seq();
    @(negedge clk);
    arm_seq();
    chk("R10 no pulse on reload", {31'b0, wdt_rst_req}, 32'h0);
    wait_pulse(10, hit); chk("R10 full reload", hit, 3);

    finish_run();
  end
endmodule